// File: doc/BRIEF.md
# Branch History Table Direction Predictor

This block guesses, for a fetch stage, whether a conditional branch will be taken. A table of small per-branch records is addressed directly by a few low bits of the program counter. There are no tags, so two branches whose counters agree in those bits share one record. A build-time parameter selects the record format. The one-bit format remembers only the last outcome. The two-bit format is a saturating counter that needs two wrong outcomes in a row before a strongly held guess changes.

Lookups are combinational: a counter value presented on the lookup pins produces a prediction in the same cycle. A second pin group carries the resolved outcome of an executed branch and writes the table at the next clock edge. Both functions may run in the same cycle. When the dynamic scheme is switched off by a control pin, the prediction comes from a static rule. A backward branch, which has a negative displacement, is guessed taken and a forward one not taken. When hint use is enabled, a predict-taken hint bit in the instruction forces a taken guess.

The update stream is qualified by `upd_valid` alone. It is accepted on every clock edge where `upd_valid` is high and never exerts back-pressure, so it has no ready signal. The table keeps training while the static rule is selected.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry predicts not taken. Two-bit entries start at the value 01 and one-bit entries start at 0.
- R2: The entry index is lk_pc[5:2] (and upd_pc[5:2]) for the default 4-bit index. Bits [1:0] and bits above 5 have no effect, so counters that agree in bits [5:2] share one entry.
- R3: In one-bit mode (ENTRY_W=1) with dyn_en=1, the prediction equals the outcome of the last accepted update at that index.
- R4: In two-bit mode (ENTRY_W=2) each entry is a counter that adds 1 on a taken update and subtracts 1 on a not-taken update, saturating at 00 and 11. The values 10 and 11 predict taken, and 00 and 01 predict not taken.
- R5: In two-bit mode, an entry saturated at 11 still predicts taken after one not-taken update and predicts not taken after a second one.
- R6: With dyn_en=0 and hint_en=0, pred_taken equals lk_back, where lk_back=1 marks a negative (backward) displacement.
- R7: With dyn_en=0 and hint_en=1, pred_taken is 1 whenever lk_hint=1. When lk_hint=0 the rule of R6 applies.
- R8: When an update and a lookup address the same index in one cycle, the lookup returns the value held before that update. The new value is visible from the next cycle on.
- R9: With upd_valid=0 the table is unchanged, whatever upd_pc and upd_taken carry.
- R10: Updates train the table while dyn_en=0. Their effect shows once dyn_en returns to 1.
- R11: For a loop branch taken 9 times and then not taken once, repeated, one-bit mode mispredicts 2 times in every pass. Two-bit mode mispredicts once per pass after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_en | input | 1 | 1 selects the table, 0 selects the static rule |
| hint_en | input | 1 | Lets the instruction hint force a taken guess in static mode |
| lk_pc | input | PC_W | Counter value of the branch being looked up |
| lk_back | input | 1 | Sign of the branch displacement (1 means backward) |
| lk_hint | input | 1 | Predict-taken hint bit from the instruction |
| pred_taken | output | 1 | Same-cycle prediction, 1 means taken |
| upd_valid | input | 1 | Resolved outcome present; accepted on every edge where it is high |
| upd_pc | input | PC_W | Counter value of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
A lookup and an update can address the same entry in one clock cycle, and that collision decides what R8 promises. The bench provokes it with directed cycles that drive the same counter value on both pin groups. It also provokes it in a long random run whose indices are drawn from a small set, so collisions are frequent. Each cycle the combinational prediction is compared, before the clock edge, with a model that still holds the old entry value. The model applies the update only after that comparison, which shows the new value from the following cycle on.

// File: rtl/bht_pkg.sv
package bht_pkg;

  // Two-bit saturating step: up on taken, down on not taken.
  function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic taken);
    logic [1:0] res;
    if (taken) res = (cur == 2'b11) ? cur : cur + 2'b01;
    else       res = (cur == 2'b00) ? cur : cur - 2'b01;
    return res;
  endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 4
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int TOP = ALIGN_W + IDX_W;

  assign idx = pc[ALIGN_W +: IDX_W];

  logic unused_bits;
  assign unused_bits = ^{pc[PC_W-1:TOP], pc[ALIGN_W-1:0]};
endmodule

// File: rtl/bht_table.sv
module bht_table #(
  parameter int IDX_W   = 4,
  parameter int ENTRY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [ENTRY_W-1:0] RST_VAL = (ENTRY_W == 1) ? '0 : ENTRY_W'(1);

  logic [ENTRY_W-1:0] mem [ENTRIES];
  logic [ENTRY_W-1:0] rd_val;
  logic [ENTRY_W-1:0] nxt;

  assign rd_val   = mem[rd_idx];
  assign rd_taken = rd_val[ENTRY_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= RST_VAL;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end

  generate
    if (ENTRY_W == 1) begin : g_last
      assign nxt = wr_taken;

      // R3
      last_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_idx != $past(wr_idx)) || (rd_taken == $past(wr_taken)));
    end else begin : g_sat
      assign nxt = bht_pkg::sat_step(mem[wr_idx], wr_taken);

      // R4
      taken_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> (rd_idx != $past(wr_idx)) || (rd_val != 2'b00));

      // R4
      nottaken_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |=> (rd_idx != $past(wr_idx)) || (rd_val != 2'b11));

      // R5
      strong_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && rd_idx == wr_idx && rd_val == 2'b11)
          |=> (rd_idx != $past(wr_idx)) || rd_taken);
    end
  endgenerate
endmodule

// File: rtl/bht_static.sv
module bht_static (
  input  logic back,
  input  logic hint,
  input  logic hint_en,
  output logic taken
);
  assign taken = (hint_en && hint) || back;
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 4,
  parameter int ENTRY_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dyn_en,
  input  logic            hint_en,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_back,
  input  logic            lk_hint,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic dyn_taken, stat_taken;

  bht_index #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_rd_idx (
    .pc(lk_pc), .idx(rd_idx));

  bht_index #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_wr_idx (
    .pc(upd_pc), .idx(wr_idx));

  bht_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_taken(dyn_taken),
    .wr_en(upd_valid), .wr_idx(wr_idx), .wr_taken(upd_taken));

  bht_static u_static (
    .back(lk_back), .hint(lk_hint), .hint_en(hint_en), .taken(stat_taken));

  assign pred_taken = dyn_en ? dyn_taken : stat_taken;

  // R7
  hint_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dyn_en && hint_en && lk_hint) |-> pred_taken);

  // R6
  sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dyn_en && !lk_hint) |-> (pred_taken == lk_back));
endmodule

// File: tb/bht_predictor_test.sv
module bht_predictor_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic dyn_en = 1, hint_en = 0, lk_back = 0, lk_hint = 0;
  logic upd_valid = 0, upd_taken = 0;
  logic [31:0] lk_pc = 0, upd_pc = 0;
  logic pred2, pred1;

  int total = 0, fails = 0;
  int m2 [16];
  int m1 [16];

  always #(PERIOD/2) clk = ~clk;

  bht_predictor #(.ENTRY_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en), .hint_en(hint_en),
    .lk_pc(lk_pc), .lk_back(lk_back), .lk_hint(lk_hint), .pred_taken(pred2),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  bht_predictor #(.ENTRY_W(1)) uut1 (
    .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en), .hint_en(hint_en),
    .lk_pc(lk_pc), .lk_back(lk_back), .lk_hint(lk_hint), .pred_taken(pred1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  function automatic int ix(input logic [31:0] pc);
    return int'(pc[5:2]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Called just after a falling edge with inputs set: compare, then advance models.
  task automatic cyc(input string req);
    int e2, e1, st;
    #1;
    st = int'((hint_en && lk_hint) || lk_back);
    e2 = dyn_en ? int'(m2[ix(lk_pc)] >= 2) : st;
    e1 = dyn_en ? m1[ix(lk_pc)] : st;
    check(pred2 == e2[0], {req, " two-bit"}, int'(pred2), e2);
    check(pred1 == e1[0], {req, " one-bit"}, int'(pred1), e1);
    if (upd_valid) begin
      if (upd_taken) m2[ix(upd_pc)] = (m2[ix(upd_pc)] == 3) ? 3 : m2[ix(upd_pc)] + 1;
      else           m2[ix(upd_pc)] = (m2[ix(upd_pc)] == 0) ? 0 : m2[ix(upd_pc)] - 1;
      m1[ix(upd_pc)] = int'(upd_taken);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; upd_valid = 0; dyn_en = 1; hint_en = 0;
    for (int i = 0; i < 16; i++) begin m2[i] = 1; m1[i] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic t);
    upd_valid = 1; upd_pc = pc; upd_taken = t; lk_pc = pc;
    cyc("R4 update");
    upd_valid = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int mis2, mis1;
    @(negedge clk);
    do_reset();

    // R1: every entry predicts not taken after reset
    for (int i = 0; i < 16; i++) begin
      lk_pc = 32'(i) << 2;
      #1;
      check(pred2 == 0 && pred1 == 0, "R1 reset state", int'({pred2, pred1}), 0);
      cyc("R1");
    end

    // R4/R5: counter at index 3
    upd(32'h0C, 1); upd(32'h0C, 1); upd(32'h0C, 1);
    lk_pc = 32'h0C; #1; check(pred2 == 1, "R4 saturated taken", int'(pred2), 1); cyc("R4");
    upd(32'h0C, 0);
    lk_pc = 32'h0C; #1; check(pred2 == 1, "R5 one miss holds", int'(pred2), 1); cyc("R5");
    upd(32'h0C, 0);
    lk_pc = 32'h0C; #1; check(pred2 == 0, "R5 two misses flip", int'(pred2), 0); cyc("R5");
    upd(32'h0C, 0); upd(32'h0C, 0);
    upd(32'h0C, 1);
    lk_pc = 32'h0C; #1; check(pred2 == 0, "R4 floor then one taken", int'(pred2), 0); cyc("R4");

    // R3: one-bit follows last outcome
    for (int k = 0; k < 6; k++) begin
      upd(32'h14, k[0]);
      lk_pc = 32'h14; #1;
      check(pred1 == k[0], "R3 last outcome", int'(pred1), int'(k[0]));
      cyc("R3");
    end

    // R2: aliasing through bits above 5 and bits [1:0]
    upd(32'h1000_0018, 1);
    lk_pc = 32'h0000_001B; #1;
    check(pred1 == 1, "R2 alias shares entry", int'(pred1), 1); cyc("R2");
    lk_pc = 32'h0000_001C; #1;
    check(pred1 == 0, "R2 neighbour untouched", int'(pred1), 0); cyc("R2");

    // R8: same-cycle collision returns old value
    upd_valid = 1; upd_pc = 32'h1C; upd_taken = 1; lk_pc = 32'h1C; #1;
    check(pred1 == 0, "R8 old value on collision", int'(pred1), 0);
    cyc("R8"); upd_valid = 0;
    lk_pc = 32'h1C; #1;
    check(pred1 == 1, "R8 new value next cycle", int'(pred1), 1); cyc("R8");

    // R9: no write without upd_valid
    upd_valid = 0; upd_pc = 32'h20; upd_taken = 1; lk_pc = 32'h24; cyc("R9");
    lk_pc = 32'h20; #1;
    check(pred1 == 0 && pred2 == 0, "R9 ignored update", int'({pred2, pred1}), 0); cyc("R9");

    // R6/R7: static sweep
    dyn_en = 0;
    for (int c = 0; c < 8; c++) begin
      hint_en = c[2]; lk_hint = c[1]; lk_back = c[0];
      #1;
      check(pred2 == ((c[2] & c[1]) | c[0]), "R6/R7 static rule", int'(pred2),
            int'((c[2] & c[1]) | c[0]));
      check(pred1 == ((c[2] & c[1]) | c[0]), "R7 static rule", int'(pred1),
            int'((c[2] & c[1]) | c[0]));
      cyc("R6");
    end
    hint_en = 0; lk_hint = 0; lk_back = 0;

    // R10: training while static
    upd(32'h28, 1); upd(32'h28, 1);
    dyn_en = 1; lk_pc = 32'h28; #1;
    check(pred2 == 1 && pred1 == 1, "R10 trained in static mode", int'({pred2, pred1}), 3);
    cyc("R10");

    // Random sweep over a small index set (frequent collisions)
    for (int n = 0; n < 3000; n++) begin
      dyn_en = ($urandom % 4) != 0; hint_en = $urandom; lk_hint = $urandom; lk_back = $urandom;
      lk_pc = {$urandom, 6'b0} | (32'($urandom % 4) << 2) | 32'($urandom % 4);
      upd_valid = $urandom; upd_taken = $urandom;
      upd_pc = {$urandom, 6'b0} | (32'($urandom % 4) << 2);
      cyc("R2/R4/R8 random");
    end
    upd_valid = 0; hint_en = 0; lk_hint = 0; lk_back = 0; dyn_en = 1;

    // R11: loop branch replay
    do_reset();
    for (int p = 0; p < 4; p++) begin
      mis2 = 0; mis1 = 0;
      for (int it = 0; it < 10; it++) begin
        lk_pc = 32'h40; upd_pc = 32'h40; upd_valid = 1; upd_taken = (it < 9);
        #1;
        if (pred2 != upd_taken) mis2++;
        if (pred1 != upd_taken) mis1++;
        cyc("R11");
      end
      upd_valid = 0;
      check(mis1 == 2, "R11 one-bit misses per pass", mis1, 2);
      check(mis2 == ((p == 0) ? 2 : 1), "R11 two-bit misses per pass", mis2, (p == 0) ? 2 : 1);
    end

    summary();
    $finish;
  end
endmodule